// File: doc/BRIEF.md
# AC-Link Power-Down and Wake Sequencer

This block sits on the controller side of an AC'97-style serial audio link. While the link is running, it tracks bit positions inside each 256-bit output frame. A frame is a 16-bit tag slot followed by twelve 20-bit data slots. The block drives the frame sync during the tag slot and passes serial output data through.

When the frame formatter presents a write to the codec power-down register with the halt bit set, the block parks the link at the end of that frame. Sync and serial-out then stay low, and the block keeps them quiet for a fixed lockout of several frame times.

The bit clock is stopped while the link is halted. All timing therefore runs on a free-running local reference clock. Three things can restart the link:
- a rising edge on any codec serial-in line, which also raises a sticky wake status flag;
- a software warm-reset request;
- a software cold-reset request.

A warm restart drives sync high for a fixed pulse width. A cold restart drives an active-low codec reset for the same width. Either way, the block then waits for the codec-ready indication before it reports the link ready again. Requests that arrive during the lockout are remembered and served when it expires. A shut-off control keeps the link parked and discards all wake requests.

Top module: `ac_link_pwrseq`

## Requirements
- R1: Reset puts the block in its reset state. In that state `link_ready`, `sync_o`, `sdout_o`, `halted` and `wake_sts` are 0, and `codec_rst_n` is 1. The block then waits for `codec_rdy`. `link_ready` reads 1 from the second clock edge after `codec_rdy` is first driven high, counting the edge that samples it.
- R2: While the link is active, each `bit_tick` advances one bit position. Slot 0 is TAG_BITS ticks long and slots 1 to NUM_SLOTS-1 are SLOT_BITS ticks each. `slot_idx` reports the current slot and `frame_mark` pulses on the first tick of slot 0. `sync_o` is high exactly while slot 0 is current. All outputs are registered one clock after the internal state.
- R3: The block sees a power-down command when `cmd_wr` is 1, `cmd_addr` equals 0x26 and `cmd_data` bit 12 is 1 on the last tick of a frame. From the next clock, `halted` is 1, `link_ready` is 0, and `sync_o` and `sdout_o` stay 0. A write to another address, or one with bit 12 clear, leaves the link active.
- R4: After the power-down frame ends, `sync_o` and `codec_rst_n` do not change for LOCK_FRAMES*FRAME_CYC clocks. A request that arrives in that window is held and acted on when the window ends. With no request, the link stays halted.
- R5: While halted or locked out, a rising edge on any `sdin` line starts a warm restart and sets `wake_sts`. Each line passes through a two-flop synchronizer before edge detection.
- R6: A warm restart holds `sync_o` high for exactly PULSE_CYC clocks while `codec_rst_n` stays 1. A software warm request does not set `wake_sts`.
- R7: A cold restart holds `codec_rst_n` low for exactly PULSE_CYC clocks with `sync_o` low. If a cold request and a warm request are pending together, the cold restart wins.
- R8: After either restart pulse, `link_ready` stays 0 until `codec_rdy` is sampled high.
- R9: `wake_sts` stays set until `wake_clr` is sampled high. A wake edge that coincides with `wake_clr` sets the flag for that clock.
- R10: While `shut_off` is 1, codec wake edges, warm requests and cold requests are all discarded. The link stays halted and `wake_sts` is unchanged.
- R11: A rising edge on `sdin` while the link is active has no effect. `wake_sts` stays 0 and the link stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock strobe per bit-clock period while the link runs |
| sdout_data | input | 1 | Serial output bit from the frame formatter |
| cmd_wr | input | 1 | The current frame carries a register write |
| cmd_addr | input | ADDR_W | Register address carried in slot 1 |
| cmd_data | input | DATA_W | Register data carried in slot 2 |
| codec_rdy | input | 1 | Codec-ready indication, synchronous to clk |
| sdin | input | N_SDIN | Codec serial-in lines, asynchronous |
| warm_req | input | 1 | Software warm-reset request, one-clock pulse |
| cold_req | input | 1 | Software cold-reset request, one-clock pulse |
| shut_off | input | 1 | Keep the link parked and discard wake requests |
| wake_clr | input | 1 | Clear the sticky wake flag |
| sync_o | output | 1 | Frame sync to the codec |
| sdout_o | output | 1 | Serial data to the codec |
| codec_rst_n | output | 1 | Active-low codec reset |
| link_ready | output | 1 | Link is active and framing |
| halted | output | 1 | Link is parked (lockout or idle halt) |
| wake_sts | output | 1 | Sticky codec wake flag |
| frame_mark | output | 1 | Pulse on the first tick of each frame |
| slot_idx | output | SLOT_W | Current slot number |

## Verification
The assertions assume the following about the inputs:
- the request pulses, `codec_rdy` and the command fields are synchronous to the local clock;
- the command fields are stable on the last tick of a frame;
- a codec holds its serial-in line high for many clocks, through the whole warm pulse, so each wake produces exactly one edge.

The stimulus raises one `sdin` line at a time and holds it until sync has fallen. It drops `codec_rdy` as soon as the link parks and raises it only after the restart pulse. It toggles `shut_off` only while every line is low and the synchronizers have settled.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef enum logic [2:0] {
    LS_ACTIVE  = 3'd0,
    LS_LOCKOUT = 3'd1,
    LS_HALTED  = 3'd2,
    LS_WARM    = 3'd3,
    LS_COLD    = 3'd4,
    LS_WAITRDY = 3'd5
  } lstate_t;
endpackage

// File: rtl/ac_sdin_wake.sv
// Per-lane two-flop synchronizer plus rising-edge detect, OR-ed across lanes.
module ac_sdin_wake #(
  parameter int N_LANES = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LANES-1:0] sdin,
  output logic               rise
);
  logic [N_LANES-1:0] lane_rise;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [2:0] sh;  // [0],[1] synchronizer, [2] previous value
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[1:0], sdin[g]};
    end
    assign lane_rise[g] = sh[1] & ~sh[2];
  end

  assign rise = |lane_rise;
endmodule

// File: rtl/ac_slot_ctr.sv
// Bit/slot position tracker inside one output frame.
module ac_slot_ctr #(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int NUM_SLOTS = 13,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  output logic [SLOT_W-1:0] slot,
  output logic              first,
  output logic              last
);
  localparam int WIDEST = (TAG_BITS > SLOT_BITS) ? TAG_BITS : SLOT_BITS;
  localparam int SBIT_W = $clog2(WIDEST);

  logic [SBIT_W-1:0] sbit;
  logic [SBIT_W-1:0] lim;

  assign lim   = (slot == '0) ? SBIT_W'(TAG_BITS - 1) : SBIT_W'(SLOT_BITS - 1);
  assign first = run & tick & (slot == '0) & (sbit == '0);
  assign last  = run & tick & (slot == SLOT_W'(NUM_SLOTS - 1)) & (sbit == SBIT_W'(SLOT_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      slot <= '0;
      sbit <= '0;
    end else if (tick) begin
      if (sbit == lim) begin
        sbit <= '0;
        slot <= (slot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot + 1'b1;
      end else begin
        sbit <= sbit + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ac_pwr_fsm.sv
// Power state machine: park, lockout, restart pulses, wait for codec ready.
module ac_pwr_fsm
  import aclk_pkg::*;
#(
  parameter int LOCK_CYC  = 20800,
  parameter int PULSE_CYC = 250
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    frame_last,
  input  logic    pd_hit,
  input  logic    wake_edge,
  input  logic    warm_req,
  input  logic    cold_req,
  input  logic    shut_off,
  input  logic    codec_rdy,
  output lstate_t st,
  output logic    wake_hit
);
  localparam int MAXC  = (LOCK_CYC > PULSE_CYC) ? LOCK_CYC : PULSE_CYC;
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [CNT_W-1:0] LOCK_LAST  = CNT_W'(LOCK_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);

  logic [CNT_W-1:0] tcnt;
  logic             pend_w, pend_c;
  logic             take_w, take_c, parked;

  assign take_c   = cold_req & ~shut_off;
  assign take_w   = (warm_req | wake_edge) & ~shut_off;
  assign parked   = (st == LS_LOCKOUT) | (st == LS_HALTED);
  assign wake_hit = wake_edge & ~shut_off & parked;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= LS_WAITRDY;
      tcnt   <= '0;
      pend_w <= 1'b0;
      pend_c <= 1'b0;
    end else begin
      case (st)
        LS_ACTIVE: begin
          if (frame_last && pd_hit) begin
            st     <= LS_LOCKOUT;
            tcnt   <= '0;
            pend_w <= 1'b0;
            pend_c <= 1'b0;
          end
        end
        LS_LOCKOUT: begin
          if (tcnt == LOCK_LAST) begin
            tcnt   <= '0;
            pend_w <= 1'b0;
            pend_c <= 1'b0;
            if (pend_c || take_c)      st <= LS_COLD;
            else if (pend_w || take_w) st <= LS_WARM;
            else                       st <= LS_HALTED;
          end else begin
            tcnt   <= tcnt + 1'b1;
            pend_c <= pend_c | take_c;
            pend_w <= pend_w | take_w;
          end
        end
        LS_HALTED: begin
          tcnt <= '0;
          if (take_c)      st <= LS_COLD;
          else if (take_w) st <= LS_WARM;
        end
        LS_WARM, LS_COLD: begin
          if (tcnt == PULSE_LAST) begin
            st   <= LS_WAITRDY;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        LS_WAITRDY: begin
          if (codec_rdy) st <= LS_ACTIVE;
        end
        default: st <= LS_WAITRDY;
      endcase
    end
  end
endmodule

// File: rtl/ac_link_pwrseq.sv
module ac_link_pwrseq
  import aclk_pkg::*;
#(
  parameter int          N_SDIN      = 3,
  parameter int          TAG_BITS    = 16,
  parameter int          SLOT_BITS   = 20,
  parameter int          NUM_SLOTS   = 13,
  parameter int          FRAME_CYC   = 5200,
  parameter int          LOCK_FRAMES = 4,
  parameter int          PULSE_CYC   = 250,
  parameter int          ADDR_W      = 7,
  parameter int          DATA_W      = 16,
  parameter logic [6:0]  PD_ADDR     = 7'h26,
  parameter int          PD_BIT      = 12,
  parameter int          SLOT_W      = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              sdout_data,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              codec_rdy,
  input  logic [N_SDIN-1:0] sdin,
  input  logic              warm_req,
  input  logic              cold_req,
  input  logic              shut_off,
  input  logic              wake_clr,
  output logic              sync_o,
  output logic              sdout_o,
  output logic              codec_rst_n,
  output logic              link_ready,
  output logic              halted,
  output logic              wake_sts,
  output logic              frame_mark,
  output logic [SLOT_W-1:0] slot_idx
);
  localparam int LOCK_CYC = LOCK_FRAMES * FRAME_CYC;
  localparam logic [DATA_W-1:0] PD_MASK = DATA_W'(1) << PD_BIT;

  lstate_t           st;
  logic              wake_edge, wake_hit;
  logic              run, f_first, f_last, pd_hit;
  logic [SLOT_W-1:0] slot;

  assign run    = (st == LS_ACTIVE);
  assign pd_hit = cmd_wr & (cmd_addr == ADDR_W'(PD_ADDR)) & ((cmd_data & PD_MASK) != '0);

  ac_sdin_wake #(.N_LANES(N_SDIN)) u_wake (
    .clk  (clk),
    .rst  (rst),
    .sdin (sdin),
    .rise (wake_edge)
  );

  ac_slot_ctr #(
    .TAG_BITS (TAG_BITS),
    .SLOT_BITS(SLOT_BITS),
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W)
  ) u_slot (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (bit_tick),
    .slot (slot),
    .first(f_first),
    .last (f_last)
  );

  ac_pwr_fsm #(
    .LOCK_CYC (LOCK_CYC),
    .PULSE_CYC(PULSE_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .frame_last(f_last),
    .pd_hit    (pd_hit),
    .wake_edge (wake_edge),
    .warm_req  (warm_req),
    .cold_req  (cold_req),
    .shut_off  (shut_off),
    .codec_rdy (codec_rdy),
    .st        (st),
    .wake_hit  (wake_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_o      <= 1'b0;
      sdout_o     <= 1'b0;
      codec_rst_n <= 1'b1;
      link_ready  <= 1'b0;
      halted      <= 1'b0;
      wake_sts    <= 1'b0;
      frame_mark  <= 1'b0;
      slot_idx    <= '0;
    end else begin
      sync_o      <= (st == LS_WARM) | (run & (slot == '0));
      sdout_o     <= run & sdout_data;
      codec_rst_n <= (st != LS_COLD);
      link_ready  <= run;
      halted      <= (st == LS_LOCKOUT) | (st == LS_HALTED);
      frame_mark  <= f_first;
      slot_idx    <= slot;
      if (wake_hit)      wake_sts <= 1'b1;
      else if (wake_clr) wake_sts <= 1'b0;
    end
  end
endmodule

// File: rtl/ac_link_pwrseq_chk.sv
module ac_link_pwrseq_chk #(
  parameter int LOCK_CYC  = 20800,
  parameter int PULSE_CYC = 250
) (
  input logic clk,
  input logic rst,
  input logic codec_rdy,
  input logic wake_clr,
  input logic sync_o,
  input logic sdout_o,
  input logic codec_rst_n,
  input logic link_ready,
  input logic halted,
  input logic wake_sts
);
  int idle_cnt, hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= 0;
      hi_cnt   <= 0;
      lo_cnt   <= 0;
    end else begin
      idle_cnt <= link_ready ? 0 : ((idle_cnt < LOCK_CYC) ? idle_cnt + 1 : idle_cnt);
      hi_cnt   <= (sync_o && !link_ready) ? hi_cnt + 1 : 0;
      lo_cnt   <= !codec_rst_n ? lo_cnt + 1 : 0;
    end
  end

  AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (rst) halted |-> (!sync_o && !sdout_o)); // R3
  AST_LOCKOUT_HELD: assert property (@(posedge clk) disable iff (rst) ($rose(sync_o) && !link_ready) |-> (idle_cnt >= LOCK_CYC)); // R4
  AST_WARM_WIDTH: assert property (@(posedge clk) disable iff (rst) ($fell(sync_o) && !link_ready) |-> (hi_cnt == PULSE_CYC)); // R6
  AST_COLD_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(codec_rst_n) |-> (lo_cnt == PULSE_CYC)); // R7
  AST_COLD_NO_SYNC: assert property (@(posedge clk) disable iff (rst) !codec_rst_n |-> !sync_o); // R7
  AST_READY_AFTER_CODEC: assert property (@(posedge clk) disable iff (rst) $rose(link_ready) |-> $past(codec_rdy, 2)); // R8
  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (rst) (wake_sts && !wake_clr) |=> wake_sts); // R9
endmodule

bind ac_link_pwrseq ac_link_pwrseq_chk #(
  .LOCK_CYC (LOCK_FRAMES * FRAME_CYC),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .codec_rdy  (codec_rdy),
  .wake_clr   (wake_clr),
  .sync_o     (sync_o),
  .sdout_o    (sdout_o),
  .codec_rst_n(codec_rst_n),
  .link_ready (link_ready),
  .halted     (halted),
  .wake_sts   (wake_sts)
);

// File: tb/sim_ac_link_pwrseq.sv
module sim_ac_link_pwrseq;
  localparam int TAG_B = 16, SLOT_B = 20, NSLOT = 13;
  localparam int FRAME_C = 64, LOCK_F = 4, PULSE = 10;
  localparam int LOCK = FRAME_C * LOCK_F;

  logic clk = 0;
  logic rst = 1;
  logic bit_tick = 0, sdout_data = 0, cmd_wr = 0, codec_rdy = 0;
  logic [6:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic [2:0] sdin = '0;
  logic warm_req = 0, cold_req = 0, shut_off = 0, wake_clr = 0;
  logic sync_o, sdout_o, codec_rst_n, link_ready, halted, wake_sts, frame_mark;
  logic [3:0] slot_idx;

  always #2 clk = ~clk;

  ac_link_pwrseq #(
    .TAG_BITS(TAG_B), .SLOT_BITS(SLOT_B), .NUM_SLOTS(NSLOT),
    .FRAME_CYC(FRAME_C), .LOCK_FRAMES(LOCK_F), .PULSE_CYC(PULSE)
  ) u0 (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .sdout_data(sdout_data),
    .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .codec_rdy(codec_rdy), .sdin(sdin), .warm_req(warm_req),
    .cold_req(cold_req), .shut_off(shut_off), .wake_clr(wake_clr),
    .sync_o(sync_o), .sdout_o(sdout_o), .codec_rst_n(codec_rst_n),
    .link_ready(link_ready), .halted(halted), .wake_sts(wake_sts),
    .frame_mark(frame_mark), .slot_idx(slot_idx)
  );

  int vecs = 0, miss = 0, cyc = 0;
  bit armed = 0, done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // mode: 0 run, 1 lockout, 2 parked, 3 warm pulse, 4 cold pulse, 5 await ready
  int mode, tmr, mslot, mbit;
  bit pend_w, pend_c;
  logic [2:0] q1, q2, q3;
  bit e_sync, e_sdout, e_rstn, e_rdy, e_halt, e_wsts, e_frame;
  int e_slot;

  always @(posedge clk) begin
    bit edge_seen, tk_c, tk_w, fl;
    cyc = cyc + 1;
    if (rst) begin
      mode = 5; tmr = 0; mslot = 0; mbit = 0; pend_w = 0; pend_c = 0;
      q1 = 0; q2 = 0; q3 = 0;
      e_sync = 0; e_sdout = 0; e_rstn = 1; e_rdy = 0; e_halt = 0;
      e_wsts = 0; e_frame = 0; e_slot = 0;
    end else begin
      e_sync  = (mode == 3) || (mode == 0 && mslot == 0);
      e_sdout = (mode == 0) && sdout_data;
      e_rstn  = (mode != 4);
      e_rdy   = (mode == 0);
      e_halt  = (mode == 1 || mode == 2);
      e_frame = (mode == 0) && bit_tick && mslot == 0 && mbit == 0;
      e_slot  = mslot;
      edge_seen = |(q2 & ~q3);
      if (edge_seen && !shut_off && (mode == 1 || mode == 2)) e_wsts = 1;
      else if (wake_clr) e_wsts = 0;
      q3 = q2; q2 = q1; q1 = sdin;
      fl   = (mode == 0) && bit_tick && mslot == NSLOT - 1 && mbit == SLOT_B - 1;
      tk_c = cold_req && !shut_off;
      tk_w = (warm_req || edge_seen) && !shut_off;
      if (mode != 0) begin
        mslot = 0; mbit = 0;
      end else if (bit_tick) begin
        if (mbit == ((mslot == 0) ? TAG_B - 1 : SLOT_B - 1)) begin
          mbit = 0;
          mslot = (mslot == NSLOT - 1) ? 0 : mslot + 1;
        end else mbit++;
      end
      case (mode)
        0: if (fl && cmd_wr && cmd_addr == 7'h26 && cmd_data[12]) begin
             mode = 1; tmr = 0; pend_w = 0; pend_c = 0;
           end
        1: if (tmr == LOCK - 1) begin
             mode = (pend_c || tk_c) ? 4 : ((pend_w || tk_w) ? 3 : 2);
             tmr = 0; pend_w = 0; pend_c = 0;
           end else begin
             tmr++; pend_c |= tk_c; pend_w |= tk_w;
           end
        2: begin
             tmr = 0;
             if (tk_c) mode = 4;
             else if (tk_w) mode = 3;
           end
        3, 4: if (tmr == PULSE - 1) begin mode = 5; tmr = 0; end else tmr++;
        default: if (codec_rdy) mode = 0;
      endcase
    end
    armed = 1;
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R2", "sync_o", sync_o, e_sync);
      chk("R3", "sdout_o", sdout_o, e_sdout);
      chk("R7", "codec_rst_n", codec_rst_n, e_rstn);
      chk("R8", "link_ready", link_ready, e_rdy);
      chk("R3", "halted", halted, e_halt);
      chk("R9", "wake_sts", wake_sts, e_wsts);
      chk("R2", "frame_mark", frame_mark, e_frame);
      chk("R2", "slot_idx", slot_idx, e_slot);
    end
  end

  // bit-clock strobe pattern (3 of every 4 clocks) and serial data
  always @(negedge clk) begin
    bit_tick   <= (cyc % 4) != 3;
    sdout_data <= ((cyc >> 1) ^ (cyc >> 3)) & 1;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      miss++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int t_halt;

  task automatic power_down();
    cmd_wr = 1; cmd_addr = 7'h26; cmd_data = 16'h1000;
    while (halted !== 1'b1) @(negedge clk);
    t_halt = cyc;
    cmd_wr = 0; cmd_data = 16'h0; codec_rdy = 0;
  endtask

  task automatic bring_up();
    idle(20);
    chk("R8", "link_ready before codec ready", link_ready, 0);
    codec_rdy = 1;
    while (link_ready !== 1'b1) @(negedge clk);
  endtask

  initial begin
    int n, t0;
    bit saw_sync;
    // R1: reset values
    idle(5);
    chk("R1", "reset link_ready", link_ready, 0);
    chk("R1", "reset codec_rst_n", codec_rst_n, 1);
    chk("R1", "reset sync_o", sync_o, 0);
    rst = 0;
    idle(10);
    chk("R1", "halted after reset", halted, 0);
    codec_rdy = 1;
    n = 0;
    while (link_ready !== 1'b1) begin @(negedge clk); n++; end
    chk("R1", "codec ready to link ready latency", n, 2);

    // R2/R3: frames with non-matching commands keep running
    cmd_wr = 1; cmd_addr = 7'h26; cmd_data = 16'h0800;
    idle(700);
    cmd_addr = 7'h24; cmd_data = 16'h1000;
    idle(700);
    cmd_wr = 0; cmd_addr = 7'h26;
    idle(400);
    chk("R3", "non power-down commands keep link", link_ready, 1);
    chk("R3", "non power-down commands halted", halted, 0);

    // R11: wake edge while active is ignored
    sdin = 3'b001; idle(12); sdin = 0; idle(12);
    chk("R11", "active edge wake_sts", wake_sts, 0);
    chk("R11", "active edge link_ready", link_ready, 1);

    // R4/R5/R6: codec wake during lockout is held, then warm pulse
    power_down();
    chk("R3", "sync_o parked", sync_o, 0);
    idle(20);
    sdin = 3'b010;
    while (sync_o !== 1'b1) @(negedge clk);
    chk("R4", "lockout length before warm", cyc - t_halt, LOCK);
    n = 0;
    while (sync_o === 1'b1) begin
      chk("R6", "codec_rst_n during warm", codec_rst_n, 1);
      @(negedge clk); n++;
    end
    chk("R6", "warm pulse width", n, PULSE);
    sdin = 0;
    chk("R5", "wake_sts after codec wake", wake_sts, 1);
    bring_up();

    // R9: clear
    wake_clr = 1; idle(1); wake_clr = 0; idle(2);
    chk("R9", "wake_sts cleared", wake_sts, 0);

    // R4/R6: idle halt, then software warm request
    power_down();
    idle(LOCK + 20);
    chk("R4", "no request stays halted", halted, 1);
    chk("R4", "no request sync low", sync_o, 0);
    warm_req = 1; idle(1); warm_req = 0;
    while (sync_o !== 1'b1) @(negedge clk);
    n = 0;
    while (sync_o === 1'b1) begin @(negedge clk); n++; end
    chk("R6", "software warm width", n, PULSE);
    chk("R6", "software warm leaves wake_sts", wake_sts, 0);
    bring_up();

    // R10 then R7: shut-off discards, then cold beats warm
    power_down();
    idle(LOCK + 10);
    shut_off = 1;
    sdin = 3'b001; idle(15); sdin = 0;
    warm_req = 1; idle(1); warm_req = 0;
    cold_req = 1; idle(1); cold_req = 0;
    idle(20);
    chk("R10", "shut_off keeps halted", halted, 1);
    chk("R10", "shut_off wake_sts", wake_sts, 0);
    chk("R10", "shut_off codec_rst_n", codec_rst_n, 1);
    shut_off = 0;
    idle(3);
    cold_req = 1; warm_req = 1; idle(1); cold_req = 0; warm_req = 0;
    while (codec_rst_n !== 1'b0) @(negedge clk);
    n = 0; saw_sync = 0;
    while (codec_rst_n === 1'b0) begin
      if (sync_o) saw_sync = 1;
      @(negedge clk); n++;
    end
    chk("R7", "cold pulse width", n, PULSE);
    chk("R7", "sync during cold", saw_sync, 0);
    bring_up();

    // R7/R5/R4: cold and codec wake both held in lockout; cold wins
    power_down();
    idle(10);
    sdin = 3'b100;
    cold_req = 1; idle(1); cold_req = 0;
    while (codec_rst_n !== 1'b0) @(negedge clk);
    chk("R4", "lockout length before cold", cyc - t_halt, LOCK);
    chk("R5", "lane 2 wake_sts", wake_sts, 1);
    n = 0;
    while (codec_rst_n === 1'b0) begin
      chk("R7", "sync low in cold", sync_o, 0);
      @(negedge clk); n++;
    end
    chk("R7", "held cold width", n, PULSE);
    sdin = 0;
    bring_up();

    // R9: set wins over a clear in the same cycle
    wake_clr = 1; idle(2);
    power_down();
    idle(LOCK + 10);
    sdin = 3'b001;
    n = 0; t0 = 0;
    while (sync_o !== 1'b1) begin
      if (wake_sts) n++;
      @(negedge clk); t0++;
    end
    sdin = 0;
    chk("R9", "wake_sts cycles under clear", n, 1);
    wake_clr = 0;
    idle(PULSE + 5);
    bring_up();
    idle(50);
    chk("R2", "link active at end", link_ready, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule